// File: doc/BRIEF.md
# Cross-Lane Vector/Scalar Exchange Unit

This block moves single values between a 64-lane vector operand and the scalar side of a wide data path. It also produces per-lane running counts of a 64-bit lane mask. Each cycle can issue one operation, chosen by a two-bit code.

The four operations are:

- A lane read picks one element of the vector source and returns it as a scalar.
- A lane write returns a copy of the destination's previous contents with one lane replaced by a scalar.
- A low-half count gives each lane the number of set bits of the low mask word that sit below that lane, plus a scalar addend.
- A high-half count does the same over the high mask word.

A single 32-bit scalar acts as the lane selector for reads and writes, and as the addend for the two counts. Results are registered and appear one cycle after issue, together with a valid strobe. The register file and instruction decode sit outside this block. The caller supplies the old destination contents and consumes the registered result.

Top module: `xlane_unit`

## Requirements
- R1: Synchronous active-high reset drives both result buses to zero and both valid strobes low on the following edge, even when an operation was in flight.
- R2: Op code 0 (read) puts the vector source element of the selected lane on `sc_out`, with `sc_valid` high in the cycle after issue.
- R3: The lane index is `lane_sel` bits [5:0]. Higher selector bits are ignored for both read and write, so 0x47 selects lane 7, 0x40 selects lane 0 and 0xFFFFFFFF selects lane 63.
- R4: Op code 1 (write) sets lane k of `vec_out` to `wr_data`, where k is the selected lane. Every other lane equals the same lane of `vec_dst_old` at issue.
- R5: Op code 2 (low count) gives lane i the count of set bits of `mask_lo` at positions below min(i,32), plus `lane_sel`. Lane 0 therefore receives the addend alone.
- R6: Op code 3 (high count) gives lane i the count of set bits of `mask_hi` at positions [i-33:0] when i>32, and zero otherwise, plus `lane_sel`. `mask_lo` has no effect on this op.
- R7: Each count result is the 32-bit sum modulo 2^32, so carries out of bit 31 are dropped.
- R8: In the cycle after an issue, exactly one valid strobe is high: `sc_valid` for a read, `vec_valid` for the other ops. Both strobes are low in the cycle after a cycle with no issue.
- R9: With no issue, `sc_out` and `vec_out` keep their last values whatever the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | An operation is presented this cycle |
| op | input | 2 | 0 read, 1 write, 2 low count, 3 high count |
| vec_src | input | 2048 | Vector source, lane i in bits [32i+31:32i] |
| vec_dst_old | input | 2048 | Previous destination contents for lane write |
| wr_data | input | 32 | Scalar written into the selected lane |
| lane_sel | input | 32 | Lane selector (bits [5:0]) or count addend |
| mask_lo | input | 32 | Mask bits for lanes 0..31 |
| mask_hi | input | 32 | Mask bits for lanes 32..63 |
| sc_out | output | 32 | Registered scalar result |
| sc_valid | output | 1 | Scalar result strobe |
| vec_out | output | 2048 | Registered vector result |
| vec_valid | output | 1 | Vector result strobe |

## Verification
The count path has two effects that can land in the same lane on the same cycle. A lane's mask count and the wrap of the addend past 2^32 both happen inside one 32-bit sum. The bench provokes this by pairing an addend near 0xFFFFFFFF with an all-ones mask. It then judges the top lanes, where both the largest count and the dropped carry appear together, against an independent per-lane model. Index masking and lane replacement also coincide on a write whose selector has high bits set. That case is judged by checking that lane 0 takes the scalar while every other lane still matches the old contents.

// File: rtl/xlane_pkg.sv
package xlane_pkg;
  typedef enum logic [1:0] {
    XL_READ  = 2'd0,
    XL_WRITE = 2'd1,
    XL_CNTLO = 2'd2,
    XL_CNTHI = 2'd3
  } xl_op_e;
endpackage

// File: rtl/xlane_pick.sv
// Selects one lane of a flattened vector.
module xlane_pick #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] vec,
  input  logic [IDXW-1:0]     idx,
  output logic [DW-1:0]       elem
);
  logic [DW-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lanes[g] = vec[g*DW +: DW];
  end

  assign elem = lanes[idx];
endmodule

// File: rtl/xlane_insert.sv
// Replaces one lane of a vector, passing the rest through.
module xlane_insert #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic [LANES*DW-1:0] old_vec,
  input  logic [IDXW-1:0]     idx,
  input  logic [DW-1:0]       val,
  output logic [LANES*DW-1:0] new_vec
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign new_vec[g*DW +: DW] = (idx == IDXW'(g)) ? val : old_vec[g*DW +: DW];
  end
endmodule

// File: rtl/xlane_prefix.sv
// Per-lane count of mask bits below the lane, for one mask half, plus an addend.
module xlane_prefix #(
  parameter int LANES = 64,
  parameter int DW    = 32,
  parameter bit HIGH  = 1'b0,
  localparam int HALFW = LANES / 2,
  localparam int CW    = $clog2(HALFW + 1)
) (
  input  logic [HALFW-1:0]    word,
  input  logic [DW-1:0]       addend,
  output logic [LANES*DW-1:0] res
);
  function automatic logic [CW-1:0] ones(input logic [HALFW-1:0] w);
    logic [CW-1:0] n;
    n = '0;
    for (int b = 0; b < HALFW; b++) n = n + CW'(w[b]);
    return n;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int NB = HIGH ? ((g > HALFW) ? (g - HALFW) : 0)
                             : ((g < HALFW) ? g : HALFW);
    localparam logic [HALFW-1:0] KEEP = (NB >= HALFW) ? {HALFW{1'b1}}
                                        : HALFW'((64'd1 << NB) - 64'd1);
    assign res[g*DW +: DW] = addend + DW'(ones(word & KEEP));
  end
endmodule

// File: rtl/xlane_unit.sv
module xlane_unit #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  issue,
  input  logic [1:0]            op,
  input  logic [LANES*DW-1:0]   vec_src,
  input  logic [LANES*DW-1:0]   vec_dst_old,
  input  logic [DW-1:0]         wr_data,
  input  logic [DW-1:0]         lane_sel,
  input  logic [LANES/2-1:0]    mask_lo,
  input  logic [LANES/2-1:0]    mask_hi,
  output logic [DW-1:0]         sc_out,
  output logic                  sc_valid,
  output logic [LANES*DW-1:0]   vec_out,
  output logic                  vec_valid
);
  import xlane_pkg::*;

  localparam int IDXW = $clog2(LANES);
  localparam int VW   = LANES * DW;

  xl_op_e          op_e;
  logic [IDXW-1:0] idx;
  logic [DW-1:0]   picked;
  logic [VW-1:0]   inserted, cnt_lo, cnt_hi, vec_next;

  assign op_e = xl_op_e'(op);
  assign idx  = lane_sel[IDXW-1:0];

  xlane_pick #(.LANES(LANES), .DW(DW)) u_pick (
    .vec(vec_src), .idx(idx), .elem(picked)
  );

  xlane_insert #(.LANES(LANES), .DW(DW)) u_ins (
    .old_vec(vec_dst_old), .idx(idx), .val(wr_data), .new_vec(inserted)
  );

  xlane_prefix #(.LANES(LANES), .DW(DW), .HIGH(1'b0)) u_cnt_lo (
    .word(mask_lo), .addend(lane_sel), .res(cnt_lo)
  );

  xlane_prefix #(.LANES(LANES), .DW(DW), .HIGH(1'b1)) u_cnt_hi (
    .word(mask_hi), .addend(lane_sel), .res(cnt_hi)
  );

  always_comb begin
    unique case (op_e)
      XL_CNTLO: vec_next = cnt_lo;
      XL_CNTHI: vec_next = cnt_hi;
      default:  vec_next = inserted;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sc_out    <= '0;
      sc_valid  <= 1'b0;
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      sc_valid  <= 1'b0;
      vec_valid <= 1'b0;
      if (issue) begin
        if (op_e == XL_READ) begin
          sc_out   <= picked;
          sc_valid <= 1'b1;
        end else begin
          vec_out   <= vec_next;
          vec_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xlane_chk.sv
module xlane_chk #(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                issue,
  input logic [1:0]          op,
  input logic [DW-1:0]       wr_data,
  input logic [DW-1:0]       lane_sel,
  input logic [DW-1:0]       sc_out,
  input logic                sc_valid,
  input logic [LANES*DW-1:0] vec_out,
  input logic                vec_valid
);
  localparam int IDXW = $clog2(LANES);

  logic [IDXW-1:0] p_idx;
  logic [DW-1:0]   p_wd;
  logic [DW-1:0]   p_add;

  always_ff @(posedge clk) begin
    p_idx <= lane_sel[IDXW-1:0];
    p_wd  <= wr_data;
    p_add <= lane_sel;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!sc_valid && !vec_valid && sc_out == '0 && vec_out == '0)); // R1

  AST_READ_STROBE: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 2'd0) |=> (sc_valid && !vec_valid)); // R2

  AST_WRITE_LANE: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 2'd1) |=> (vec_out[int'(p_idx)*DW +: DW] == p_wd)); // R4

  AST_LO_LANE0: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 2'd2) |=> (vec_out[DW-1:0] == p_add)); // R5

  AST_HI_LOW_LANES: assert property (@(posedge clk) disable iff (rst)
    (issue && op == 2'd3) |=> (vec_out[DW-1:0] == p_add)); // R6

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !(sc_valid && vec_valid)); // R8

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    !issue |=> (!sc_valid && !vec_valid)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!issue && !$past(rst)) |=> ($stable(sc_out) && $stable(vec_out))); // R9
endmodule

bind xlane_unit xlane_chk #(.LANES(LANES), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .issue(issue), .op(op), .wr_data(wr_data),
  .lane_sel(lane_sel), .sc_out(sc_out), .sc_valid(sc_valid),
  .vec_out(vec_out), .vec_valid(vec_valid)
);

// File: tb/sim_xlane_unit.sv
`timescale 1ns/1ps
module sim_xlane_unit;
  localparam int LANES = 64;
  localparam int DW    = 32;
  localparam int VW    = LANES * DW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            issue = 1'b0;
  logic [1:0]      op = '0;
  logic [VW-1:0]   vec_src = '0, vec_dst_old = '0;
  logic [DW-1:0]   wr_data = '0, lane_sel = '0;
  logic [31:0]     mask_lo = '0, mask_hi = '0;
  logic [DW-1:0]   sc_out;
  logic            sc_valid, vec_valid;
  logic [VW-1:0]   vec_out;

  int  total = 0, fails = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  xlane_unit #(.LANES(LANES), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .issue(issue), .op(op), .vec_src(vec_src),
    .vec_dst_old(vec_dst_old), .wr_data(wr_data), .lane_sel(lane_sel),
    .mask_lo(mask_lo), .mask_hi(mask_hi), .sc_out(sc_out),
    .sc_valid(sc_valid), .vec_out(vec_out), .vec_valid(vec_valid)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [31:0] sel;
    logic [31:0] wd;
    logic [31:0] mlo;
    logic [31:0] mhi;
    logic [31:0] sa;
    logic [31:0] sb;
    logic [7:0]  probe;
    logic [31:0] exp;
    logic [7:0]  req;
  } row_t;

  localparam int NROWS = 15;
  localparam row_t ROWS [NROWS] = '{
    '{2'd0, 32'h5,        32'h0,        32'h0,        32'h0,        32'h10000000, 32'h0,   8'd5,  32'h10000005, 8'd2}, // R2
    '{2'd0, 32'h47,       32'h0,        32'h0,        32'h0,        32'hABCD0000, 32'h0,   8'd7,  32'hABCD0007, 8'd3}, // R3
    '{2'd0, 32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'h0,        32'h0,   8'd63, 32'h0000003F, 8'd3}, // R3
    '{2'd1, 32'd10,       32'hDEADBEEF, 32'h0,        32'h0,        32'h0,        32'h100, 8'd10, 32'hDEADBEEF, 8'd4}, // R4
    '{2'd1, 32'd10,       32'hDEADBEEF, 32'h0,        32'h0,        32'h0,        32'h100, 8'd11, 32'h0000010B, 8'd4}, // R4
    '{2'd1, 32'h40,       32'h12345678, 32'h0,        32'h0,        32'h0,        32'h200, 8'd0,  32'h12345678, 8'd3}, // R3
    '{2'd2, 32'd5,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,   8'd20, 32'h00000019, 8'd5}, // R5
    '{2'd2, 32'd0,        32'h0,        32'h000000F0, 32'h0,        32'h0,        32'h0,   8'd6,  32'h00000002, 8'd5}, // R5
    '{2'd2, 32'd0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,   8'd50, 32'h00000020, 8'd5}, // R5
    '{2'd3, 32'd0,        32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,   8'd32, 32'h00000000, 8'd6}, // R6
    '{2'd3, 32'd0,        32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,   8'd40, 32'h00000008, 8'd6}, // R6
    '{2'd3, 32'd1,        32'h0,        32'h0,        32'h80000001, 32'h0,        32'h0,   8'd63, 32'h00000002, 8'd6}, // R6
    '{2'd3, 32'hFFFFFFF0, 32'h0,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,   8'd63, 32'h0000000F, 8'd7}, // R7
    '{2'd2, 32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,   8'd1,  32'h00000000, 8'd7}, // R7
    '{2'd3, 32'd7,        32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,   8'd50, 32'h00000007, 8'd6}  // R6
  };

  function automatic logic [VW-1:0] fill(input logic [31:0] s);
    logic [VW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*DW +: DW] = s ^ 32'(i);
    return r;
  endfunction

  function automatic logic [VW-1:0] model(input row_t t);
    logic [VW-1:0] r;
    r = fill(t.sb);
    for (int i = 0; i < LANES; i++) begin
      int lim, cnt;
      cnt = 0;
      if (t.op == 2'd1) begin
        if (i == int'(t.sel[5:0])) r[i*DW +: DW] = t.wd;
      end else begin
        if (t.op == 2'd2) lim = (i < 32) ? i : 32;
        else lim = (i > 32) ? i - 32 : 0;
        for (int j = 0; j < 32; j++)
          if (j < lim && ((t.op == 2'd2) ? t.mlo[j] : t.mhi[j])) cnt++;
        r[i*DW +: DW] = t.sel + 32'(cnt);
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [VW-1:0] exp);
    int bad;
    bad = -1;
    total++;
    for (int i = LANES - 1; i >= 0; i--)
      if (vec_out[i*DW +: DW] !== exp[i*DW +: DW]) bad = i;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s lane %0d actual=%h expected=%h", req, bad,
               vec_out[bad*DW +: DW], exp[bad*DW +: DW]);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [VW-1:0] last_vec;
    logic [31:0]   last_sc;
    last_vec = '0;
    last_sc  = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state after reset
    check("R1 reset sc_out", 64'(sc_out), 64'h0);
    check("R1 reset vec_out", 64'(|vec_out), 64'h0);
    check("R1 reset strobes", {62'h0, sc_valid, vec_valid}, 64'h0);

    for (int k = 0; k < NROWS; k++) begin
      row_t t;
      string tag;
      t = ROWS[k];
      tag = $sformatf("R%0d row %0d", t.req, k);
      @(negedge clk);
      issue       = 1'b1;
      op          = t.op;
      lane_sel    = t.sel;
      wr_data     = t.wd;
      mask_lo     = t.mlo;
      mask_hi     = t.mhi;
      vec_src     = fill(t.sa);
      vec_dst_old = fill(t.sb);
      @(negedge clk);
      issue = 1'b0;
      if (t.op == 2'd0) begin
        check(tag, 64'(sc_out), 64'(t.exp));
        // R8: read raises only the scalar strobe
        check({"R8 ", tag}, {62'h0, sc_valid, vec_valid}, 64'h2);
        last_sc = t.exp;
      end else begin
        check(tag, 64'(vec_out[int'(t.probe)*DW +: DW]), 64'(t.exp));
        check_vec({tag, " all lanes"}, model(t));
        // R8: vector ops raise only the vector strobe
        check({"R8 ", tag}, {62'h0, sc_valid, vec_valid}, 64'h1);
        last_vec = model(t);
      end
    end

    // R9: idle cycles with changing inputs leave results untouched
    for (int c = 0; c < 3; c++) begin
      vec_src     = fill(32'h5A5A0000 + 32'(c));
      vec_dst_old = fill(32'h33330000);
      lane_sel    = 32'(c);
      mask_lo     = 32'hFFFFFFFF;
      op          = 2'(c);
      @(negedge clk);
    end
    check("R9 sc_out hold", 64'(sc_out), 64'(last_sc));
    check_vec("R9 vec_out hold", last_vec);
    check("R8 idle strobes", {62'h0, sc_valid, vec_valid}, 64'h0);

    // R4/R3: write with high selector bits keeps all untouched lanes
    @(negedge clk);
    issue = 1'b1; op = 2'd1; lane_sel = 32'hFFFFFFC0; wr_data = 32'hCAFEF00D;
    vec_dst_old = fill(32'h77770000);
    @(negedge clk);
    issue = 1'b0;
    check("R4 lane0 written", 64'(vec_out[31:0]), 64'hCAFEF00D);
    check("R4 lane1 kept", 64'(vec_out[63:32]), 64'h77770001);
    check("R4 lane63 kept", 64'(vec_out[VW-1 -: 32]), 64'h7777003F);

    // R1: reset right after an issue clears the outputs
    issue = 1'b1; op = 2'd0; lane_sel = 32'd3; vec_src = fill(32'h44440000);
    @(negedge clk);
    issue = 1'b0;
    rst   = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run sc_out", 64'(sc_out), 64'h0);
    check("R1 mid-run vec_out", 64'(|vec_out), 64'h0);
    check("R1 mid-run strobes", {62'h0, sc_valid, vec_valid}, 64'h0);

    finish_run();
  end
endmodule